// File: doc/BRIEF.md
# Receive Character Queue with Per-Byte Error Tags and Quiet-Line Time-Out

This block sits between a serial receive engine and a host bus. Every character the engine completes arrives as one write strobe carrying 8 data bits and 3 error tags. The block keeps the tags with their byte through the queue, so the status the host sees always describes the byte it is about to read. The oldest entry is presented as the holding register, and its tags are shown as three line-status bits. A host read of the holding register removes that entry. The next entry, with its own tags, appears on the following cycle.

After reset the block holds at most one character, which is single-holding-register behaviour. Raising the queue enable lets it hold up to 64 entries. Any change of that enable empties the queue. A data-ready interrupt is raised when enough characters wait: one in single-register mode, or a level picked by a 2-bit code in queue mode. A quiet-line time-out interrupt is raised when characters have been waiting with no write and no host read for a span that scales with the word length. Both interrupts share one enable input.

Top module: `rx_fifo_tagged`

## Requirements
- R1: In queue mode the block stores up to DEPTH (default 64) entries of 8 data bits plus 3 tags and returns them in arrival order. The head entry's data appears on `head_data` and its tags appear on `head_tags`, with `head_tags[0]` being `wr_tags[0]` as written.
- R2: A host read (`rd_en`) of a non-empty queue removes the head, and the next entry appears on `head_data`/`head_tags` in the cycle after the read. A read of an empty queue changes nothing. While the queue is empty, `head_data` and `head_tags` are zero and `data_avail` is low.
- R3: After reset the queue is empty, `overrun` is low, both interrupts are low, and the block is in single-register mode until it sees `fifo_en` high.
- R4: While `fifo_en` is low the block holds at most one character.
- R5: A write that arrives when the current capacity is used up is discarded and sets the sticky `overrun` flag. A status read (`lsr_rd`) clears the flag. If a discarded write and a status read fall in the same cycle, `overrun` is left set.
- R6: Any change of `fifo_en` empties the queue on the next clock edge. A write in that same cycle is discarded and does not set `overrun`.
- R7: With `rdy_int_en` high, `irq_rx_data` is high when at least one character waits in single-register mode. In queue mode it is high when the fill reaches the trigger selected by `trig_sel`: code 0 → 8, 1 → 16, 2 → 56, 3 → 60 entries.
- R8: In queue mode, with data waiting, the time-out flag sets on the N-th `bit_tick` after the last write or read, where N = 4·(5+`word_len`) + 12 (32, 36, 40 or 44). No time-out is raised in single-register mode.
- R9: An accepted write or a host read restarts the time-out count. A host read also clears a pending time-out.
- R10: With `rdy_int_en` low, both `irq_rx_data` and `irq_timeout` are low. A pending time-out still reappears when the enable returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 = queue mode (DEPTH entries), 0 = single holding register |
| rdy_int_en | input | 1 | Enable for both receive interrupts |
| trig_sel | input | 2 | Queue-mode trigger code: 0→8, 1→16, 2→56, 3→60 |
| word_len | input | 2 | Word length code, data bits = 5 + code |
| bit_tick | input | 1 | One-cycle pulse per serial bit time |
| wr_en | input | 1 | Character-complete strobe from the receive engine |
| wr_data | input | 8 | Received character |
| wr_tags | input | 3 | Error tags of the received character |
| rd_en | input | 1 | Host read of the holding register |
| lsr_rd | input | 1 | Host read of line status (clears overrun) |
| head_data | output | 8 | Holding register: oldest character |
| head_tags | output | 3 | Tags of the oldest character (status bits 2 to 4) |
| data_avail | output | 1 | At least one character waiting |
| overrun | output | 1 | Sticky flag for a discarded write |
| irq_rx_data | output | 1 | Data-ready interrupt |
| irq_timeout | output | 1 | Quiet-line time-out interrupt |

## Verification
The assertions take every strobe as a single-cycle synchronous pulse. They also assume the host does not expect a write to land in the cycle where `fifo_en` toggles, since the flush property expects an empty queue afterwards. The time-out properties assume `word_len` stays put during a measurement. The stimulus drives all inputs half a cycle away from the capturing edge. It changes mode, trigger code and word length only between sweeps, and it never toggles the mode together with a write.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int DATA_W    = 8;
    localparam int TAG_W     = 3;
    localparam int QUIET_MAX = 4 * (5 + 3) + 12;
    localparam int QT_W      = $clog2(QUIET_MAX + 1);

    typedef struct packed {
        logic [TAG_W-1:0]  tags;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    // Fill level that raises the data-ready interrupt in queue mode.
    function automatic int unsigned trig_level(input logic [1:0] sel,
                                               input int unsigned depth);
        case (sel)
            2'd0:    return depth / 8;
            2'd1:    return depth / 4;
            2'd2:    return depth - 8;
            default: return depth - 4;
        endcase
    endfunction

    // Quiet span in bit times: four words of the configured length plus twelve.
    function automatic int unsigned quiet_limit(input logic [1:0] wl);
        return 4 * (5 + int'(wl)) + 12;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [CW-1:0] cap,
    input  logic          wr_en,
    input  rx_entry_t     wr_entry,
    input  logic          rd_en,
    output rx_entry_t     head,
    output logic [CW-1:0] level,
    output logic          pushed,
    output logic          popped,
    output logic          dropped
);

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          room;

    assign room    = (level < cap);
    assign pushed  = wr_en && !flush && room;
    assign dropped = wr_en && !flush && !room;
    assign popped  = rd_en && !flush && (level != '0);

    always_ff @(posedge clk) begin
        if (pushed) begin
            mem[wr_ptr] <= wr_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (pushed) begin
                wr_ptr <= wr_ptr + AW'(1);
            end
            if (popped) begin
                rd_ptr <= rd_ptr + AW'(1);
            end
            case ({pushed, popped})
                2'b10:   level <= level + CW'(1);
                2'b01:   level <= level - CW'(1);
                default: level <= level;
            endcase
        end
    end

    assign head = (level != '0) ? mem[rd_ptr] : '0;

endmodule

// File: rtl/rxq_quiet_timer.sv
module rxq_quiet_timer
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic       restart,
    input  logic       clear,
    input  logic       bit_tick,
    input  logic [1:0] word_len,
    output logic       expired
);

    logic [QT_W-1:0] ticks;
    logic [QT_W-1:0] limit;
    logic [QT_W-1:0] ticks_nx;

    assign limit    = QT_W'(quiet_limit(word_len));
    assign ticks_nx = ticks + QT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ticks   <= '0;
            expired <= 1'b0;
        end else begin
            if (clear || !active) begin
                expired <= 1'b0;
            end
            if (!active || restart) begin
                ticks <= '0;
            end else if (bit_tick && !expired) begin
                if (ticks_nx >= limit) begin
                    expired <= 1'b1;
                end else begin
                    ticks <= ticks_nx;
                end
            end
        end
    end

endmodule

// File: rtl/rxq_irq_gen.sv
module rxq_irq_gen
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          fifo_en,
    input  logic          irq_en,
    input  logic [1:0]    trig_sel,
    input  logic [CW-1:0] level,
    input  logic          quiet,
    output logic          irq_rx_data,
    output logic          irq_timeout
);

    logic [CW-1:0] thresh;

    assign thresh      = fifo_en ? CW'(trig_level(trig_sel, DEPTH)) : CW'(1);
    assign irq_rx_data = irq_en && (level >= thresh);
    assign irq_timeout = irq_en && fifo_en && quiet;

endmodule

// File: rtl/rx_fifo_tagged.sv
module rx_fifo_tagged
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_en,
    input  logic              rdy_int_en,
    input  logic [1:0]        trig_sel,
    input  logic [1:0]        word_len,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TAG_W-1:0]  wr_tags,
    input  logic              rd_en,
    input  logic              lsr_rd,
    output logic [DATA_W-1:0] head_data,
    output logic [TAG_W-1:0]  head_tags,
    output logic              data_avail,
    output logic              overrun,
    output logic              irq_rx_data,
    output logic              irq_timeout
);

    logic          mode_q;
    logic          flush;
    logic [CW-1:0] cap;
    logic [CW-1:0] fill_level;
    rx_entry_t     in_entry;
    rx_entry_t     head;
    logic          pushed;
    logic          popped;
    logic          dropped;
    logic          quiet;
    logic          overrun_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
        end else begin
            mode_q <= fifo_en;
        end
    end

    assign flush    = (fifo_en != mode_q);
    assign cap      = fifo_en ? CW'(DEPTH) : CW'(1);
    assign in_entry = '{tags: wr_tags, data: wr_data};

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .cap      (cap),
        .wr_en    (wr_en),
        .wr_entry (in_entry),
        .rd_en    (rd_en),
        .head     (head),
        .level    (fill_level),
        .pushed   (pushed),
        .popped   (popped),
        .dropped  (dropped)
    );

    rxq_quiet_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .active   (fifo_en && (fill_level != '0)),
        .restart  (pushed || popped),
        .clear    (popped || flush),
        .bit_tick (bit_tick),
        .word_len (word_len),
        .expired  (quiet)
    );

    rxq_irq_gen #(.DEPTH(DEPTH)) u_irq (
        .fifo_en     (fifo_en),
        .irq_en      (rdy_int_en),
        .trig_sel    (trig_sel),
        .level       (fill_level),
        .quiet       (quiet),
        .irq_rx_data (irq_rx_data),
        .irq_timeout (irq_timeout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            overrun_q <= 1'b0;
        end else if (dropped) begin
            overrun_q <= 1'b1;
        end else if (lsr_rd) begin
            overrun_q <= 1'b0;
        end
    end

    assign head_data  = head.data;
    assign head_tags  = head.tags;
    assign data_avail = (fill_level != '0);
    assign overrun    = overrun_q;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          fifo_en,
    input logic          rdy_int_en,
    input logic [1:0]    trig_sel,
    input logic          wr_en,
    input logic          rd_en,
    input logic          lsr_rd,
    input logic [7:0]    head_data,
    input logic [2:0]    head_tags,
    input logic          data_avail,
    input logic          overrun,
    input logic          irq_rx_data,
    input logic          irq_timeout,
    input logic [CW-1:0] level,
    input logic          dropped
);

    p_level_bound_r1: assert property (@(posedge clk) disable iff (rst)
        level <= CW'(DEPTH));

    p_empty_head_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !data_avail |-> (head_data == 8'd0 && head_tags == 3'd0));

    p_single_cap_r4: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && $stable(fifo_en)) |-> level <= CW'(1));

    p_drop_sets_r5: assert property (@(posedge clk) disable iff (rst)
        dropped |=> overrun);

    p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (overrun && !lsr_rd) |=> overrun);

    p_mode_flush_r6: assert property (@(posedge clk) disable iff (rst)
        (fifo_en != $past(fifo_en)) |=> !data_avail);

    p_full_trigger_r7: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && rdy_int_en && level == CW'(DEPTH)) |-> irq_rx_data);

    p_single_ready_r7: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && rdy_int_en && data_avail) |-> irq_rx_data);

    p_timeout_has_data_r8: assert property (@(posedge clk) disable iff (rst)
        irq_timeout |-> data_avail);

    p_read_clears_timeout_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && data_avail && !wr_en) |=> !irq_timeout);

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
        !rdy_int_en |-> (!irq_rx_data && !irq_timeout));

endmodule

bind rx_fifo_tagged rxq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fifo_en     (fifo_en),
    .rdy_int_en  (rdy_int_en),
    .trig_sel    (trig_sel),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .lsr_rd      (lsr_rd),
    .head_data   (head_data),
    .head_tags   (head_tags),
    .data_avail  (data_avail),
    .overrun     (overrun),
    .irq_rx_data (irq_rx_data),
    .irq_timeout (irq_timeout),
    .level       (fill_level),
    .dropped     (dropped)
);

// File: tb/sim_rx_fifo_tagged.sv
`timescale 1ns/1ps
module sim_rx_fifo_tagged;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_en = 1'b0;
    logic       rdy_int_en = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic [1:0] word_len = 2'd0;
    logic       bit_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [2:0] wr_tags = 3'd0;
    logic       rd_en = 1'b0;
    logic       lsr_rd = 1'b0;
    logic [7:0] head_data;
    logic [2:0] head_tags;
    logic       data_avail;
    logic       overrun;
    logic       irq_rx_data;
    logic       irq_timeout;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rx_fifo_tagged u0 (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .rdy_int_en(rdy_int_en),
        .trig_sel(trig_sel), .word_len(word_len), .bit_tick(bit_tick),
        .wr_en(wr_en), .wr_data(wr_data), .wr_tags(wr_tags), .rd_en(rd_en),
        .lsr_rd(lsr_rd), .head_data(head_data), .head_tags(head_tags),
        .data_avail(data_avail), .overrun(overrun), .irq_rx_data(irq_rx_data),
        .irq_timeout(irq_timeout)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] t);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_tags = t;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic status_read();
        @(negedge clk);
        lsr_rd = 1'b1;
        @(negedge clk);
        lsr_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
        end
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk);
        fifo_en = m;
        @(negedge clk);
    endtask

    function automatic int exp_trig(input int sel);
        return (sel == 0) ? 8 : (sel == 1) ? 16 : (sel == 2) ? 56 : 60;
    endfunction

    function automatic int pat_data(input int sel, input int i);
        return (i * 7 + sel * 13 + 1) % 256;
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete actual=0 expected=1");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R3: reset state
        check("R3 data_avail", data_avail, 0);
        check("R3 overrun", overrun, 0);
        check("R3 irq_rx_data", irq_rx_data, 0);
        check("R3 irq_timeout", irq_timeout, 0);
        check("R3 head_data", head_data, 0);

        // R2: read of empty queue is ignored
        pop();
        check("R2 empty read data_avail", data_avail, 0);
        rdy_int_en = 1'b1;
        set_mode(1'b1);

        // R1, R7, R5, R2: fill and drain for every trigger code
        for (int sel = 0; sel < 4; sel++) begin
            trig_sel = 2'(sel);
            for (int i = 0; i < 64; i++) begin
                push(8'(pat_data(sel, i)), 3'((i + sel) % 8));
                check($sformatf("R7 trig code %0d fill %0d", sel, i + 1),
                      irq_rx_data, (i + 1 >= exp_trig(sel)) ? 1 : 0);
            end
            check("R1 head after fill", head_data, pat_data(sel, 0));
            if (sel == 0) begin
                @(negedge clk);
                wr_en = 1'b1; lsr_rd = 1'b1; wr_data = 8'hAA;
                @(negedge clk);
                wr_en = 1'b0; lsr_rd = 1'b0;
                check("R5 drop with status read keeps overrun", overrun, 1);
                status_read();
                check("R5 status read clears overrun", overrun, 0);
            end
            push(8'hEE, 3'd7);
            check("R5 overrun on full", overrun, 1);
            check("R5 head kept on drop", head_data, pat_data(sel, 0));
            status_read();
            check("R5 overrun cleared", overrun, 0);
            for (int i = 0; i < 64; i++) begin
                check("R1 head data order", head_data, pat_data(sel, i));
                check("R1 head tags order", head_tags, (i + sel) % 8);
                pop();
            end
            check("R2 empty after drain", data_avail, 0);
            check("R2 head zero when empty", head_data, 0);
            check("R2 tags zero when empty", head_tags, 0);
        end

        // R2: empty read does not move the head
        pop();
        push(8'h3C, 3'd5);
        check("R2 head after empty read", head_data, 8'h3C);
        check("R2 tags after empty read", head_tags, 5);
        pop();

        // R6: mode change flushes
        push(8'h01, 3'd1);
        push(8'h02, 3'd2);
        set_mode(1'b0);
        check("R6 flush on mode change", data_avail, 0);

        // R4: single-register mode
        push(8'h5A, 3'd3);
        check("R7 single mode ready irq", irq_rx_data, 1);
        push(8'h11, 3'd0);
        check("R4 second write dropped overrun", overrun, 1);
        check("R4 first byte kept", head_data, 8'h5A);
        check("R4 first tags kept", head_tags, 3);
        ticks(50);
        check("R8 no timeout in single mode", irq_timeout, 0);
        pop();
        check("R4 one byte only", data_avail, 0);
        status_read();

        // R6: toggle back also flushes
        push(8'h77, 3'd1);
        set_mode(1'b1);
        check("R6 flush on enable", data_avail, 0);

        // R8, R9: time-out per word length
        for (int wl = 0; wl < 4; wl++) begin
            int lim;
            word_len = 2'(wl);
            lim = 4 * (5 + wl) + 12;
            push(8'(wl), 3'd0);
            ticks(lim - 1);
            check($sformatf("R8 wl%0d before limit", wl), irq_timeout, 0);
            ticks(1);
            check($sformatf("R8 wl%0d at limit", wl), irq_timeout, 1);
            pop();
            check("R9 read clears timeout", irq_timeout, 0);
        end

        // R9: restart on write and on read, R10 gating
        word_len = 2'd0;
        push(8'hA1, 3'd1);
        push(8'hA2, 3'd2);
        ticks(31);
        push(8'hA3, 3'd3);
        ticks(31);
        check("R9 write restarts count", irq_timeout, 0);
        ticks(1);
        check("R9 timeout after restart", irq_timeout, 1);
        rdy_int_en = 1'b0;
        @(negedge clk);
        check("R10 timeout gated", irq_timeout, 0);
        check("R10 ready gated", irq_rx_data, 0);
        rdy_int_en = 1'b1;
        @(negedge clk);
        check("R10 pending timeout returns", irq_timeout, 1);
        pop();
        check("R9 read clears", irq_timeout, 0);
        ticks(31);
        check("R9 read restarts count", irq_timeout, 0);
        ticks(1);
        check("R9 expires again", irq_timeout, 1);
        pop();
        pop();
        check("R2 drained", data_avail, 0);

        finish_run();
    end

endmodule